// File: doc/BRIEF.md
# Trimmed Seconds Real-Time Counter with Match Events

This block keeps wall-clock time in whole seconds from a slow timebase strobe of nominally 32.768 kHz. A down-counting predivider turns the strobes into a one-second tick. On each tick a 32-bit seconds counter advances, and a sub-second counter, which counts strobes in 1/32768 s units, returns to zero. Every second normally lasts `NOM_RELOAD + 1` strobes. The nominal reload is 0x7FFF. One second out of every 64 lasts `TRIM + 1` strobes instead, where TRIM is a 16-bit programmable value. This lets software pull the long-term rate towards the true crystal frequency.

Two seconds compare registers each raise a one-cycle event when the seconds count reaches their value. The first comparator can also require the sub-second count to equal a programmed sub-second value, which places its event inside a second. Software uses a simple write/read register port to load the time, set the compares and the trim, and read back both counts. Time advances only while the enable input is high.

Top module: `trim_rtc`

## Requirements
- R1: After reset the seconds count and the sub-second count read 0, the trim register reads NOM_RELOAD, both seconds compare registers read all ones, and no event is raised.
- R2: Each clock with `rtc_en` and `tb_stb` both high is one strobe. A strobe either adds one to the sub-second count (address 5) or, when the predivider has run out, adds one to the seconds count (address 0). With the default reload a second is NOM_RELOAD+1 strobes.
- R3: On the strobe that advances the seconds count, the sub-second count becomes 0.
- R4: A 6-bit count of elapsed seconds picks the reload. The second that starts when this count wraps to 0, which is the 64th, 128th and so on after reset, lasts TRIM+1 strobes. TRIM is the low 16 bits written at address 4. Every other second lasts NOM_RELOAD+1 strobes.
- R5: While `rtc_en` or `tb_stb` is low, the seconds count, the sub-second count and the predivider all hold.
- R6: A write to address 0 sets the seconds count to the written value. If a seconds tick happens in the same cycle, the write wins.
- R7: Compare register 1 (address 2) raises `match_evt[1]` when the seconds count equals it.
- R8: Compare register 0 (address 1) raises `match_evt[0]` on seconds equality when bit 16 of address 3 is clear. When that bit is set, the event also requires the sub-second count to equal bits 15:0 of address 3.
- R9: Each event is a pulse one clock long. It is raised in the cycle after the counters first satisfy the compare, and it is not raised again while the compare stays true. A new pulse needs the compare to become true again.
- R10: Writes to address 5 and to addresses 6 and 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_en | input | 1 | Counting enable |
| tb_stb | input | 1 | One-clock strobe per timebase period (32.768 kHz) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | SEC_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | SEC_W | Register read data (combinational) |
| match_evt | output | 2 | One pulse per compare event, bit i for compare register i |

## Verification
The bench runs the counter through 64 seconds so that the wrap of the seconds-modulo count loads a short trim second. A design that applied the trim in the wrong second, or applied it in every second, would put the seconds count off by one at a known strobe count. A load written in the same cycle as a tick must give the written value, not that value plus one. The bench holds a compare true across many cycles and then re-enters it with a load. An event that is level-based, or that never re-arms, shows up as a wrong pulse count. The qualified compare is run with a seconds match but the wrong sub-second count, so a comparator that ignored the qualify bit would fire too early.

// File: rtl/trim_rtc_pkg.sv
package trim_rtc_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_MATCH = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_SECS   = 3'd0,
        REG_MATCH0 = 3'd1,
        REG_MATCH1 = 3'd2,
        REG_SUBM   = 3'd3,
        REG_TRIM   = 3'd4,
        REG_SUBCNT = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/trim_rtc_prediv.sv
module trim_rtc_prediv #(
    parameter int               SUB_W      = 16,
    parameter int               MOD_W      = 6,
    parameter logic [SUB_W-1:0] NOM_RELOAD = 16'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SUB_W-1:0] trim,
    output logic             sec_tick,
    output logic [SUB_W-1:0] subsec
);

    typedef struct packed {
        logic [SUB_W-1:0] prediv;
        logic [SUB_W-1:0] subsec;
        logic [MOD_W-1:0] modcnt;
    } pd_state_t;

    pd_state_t q, d;

    always_comb begin
        d        = q;
        sec_tick = step && (q.prediv == '0);
        if (step) begin
            if (q.prediv == '0) begin
                d.modcnt = q.modcnt + 1'b1;
                d.prediv = (d.modcnt == '0) ? trim : NOM_RELOAD;
                d.subsec = '0;
            end else begin
                d.prediv = q.prediv - 1'b1;
                d.subsec = q.subsec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prediv <= NOM_RELOAD;
            q.subsec <= '0;
            q.modcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign subsec = q.subsec;

endmodule

// File: rtl/trim_rtc_match.sv
module trim_rtc_match #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] subsec,
    input  logic [SEC_W-1:0] cmp_sec,
    input  logic [SUB_W-1:0] cmp_sub,
    input  logic             qual,
    output logic             evt
);

    typedef struct packed {
        logic hit;
        logic evt;
    } mt_state_t;

    mt_state_t q, d;
    logic      cond;

    always_comb begin
        cond  = (sec == cmp_sec) && (!qual || (subsec == cmp_sub));
        d.hit = cond;
        d.evt = cond && !q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign evt = q.evt;

endmodule

// File: rtl/trim_rtc.sv
module trim_rtc
    import trim_rtc_pkg::*;
#(
    parameter int               SEC_W      = 32,
    parameter int               SUB_W      = 16,
    parameter int               MOD_W      = 6,
    parameter logic [SUB_W-1:0] NOM_RELOAD = 16'h7FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rtc_en,
    input  logic                 tb_stb,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [SEC_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [SEC_W-1:0]     rd_data,
    output logic [NUM_MATCH-1:0] match_evt
);

    typedef struct packed {
        logic [SEC_W-1:0]                sec;
        logic [NUM_MATCH-1:0][SEC_W-1:0] cmp;
        logic [SUB_W-1:0]                sub_cmp;
        logic                            sub_qual;
        logic [SUB_W-1:0]                trim;
    } rtc_state_t;

    rtc_state_t       q, d;
    logic             sec_tick;
    logic [SUB_W-1:0] sub_cnt;
    logic [SEC_W-1:0] sec_cnt;

    trim_rtc_prediv #(
        .SUB_W     (SUB_W),
        .MOD_W     (MOD_W),
        .NOM_RELOAD(NOM_RELOAD)
    ) u_prediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (rtc_en && tb_stb),
        .trim    (q.trim),
        .sec_tick(sec_tick),
        .subsec  (sub_cnt)
    );

    always_comb begin
        d = q;
        if (sec_tick) begin
            d.sec = q.sec + 1'b1;
        end
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_SECS:   d.sec    = wr_data;
                REG_MATCH0: d.cmp[0] = wr_data;
                REG_MATCH1: d.cmp[1] = wr_data;
                REG_SUBM: begin
                    d.sub_cmp  = wr_data[SUB_W-1:0];
                    d.sub_qual = wr_data[SUB_W];
                end
                REG_TRIM:   d.trim   = wr_data[SUB_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sec      <= '0;
            q.cmp      <= '1;
            q.sub_cmp  <= '0;
            q.sub_qual <= 1'b0;
            q.trim     <= NOM_RELOAD;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            REG_SECS:   rd_data = q.sec;
            REG_MATCH0: rd_data = q.cmp[0];
            REG_MATCH1: rd_data = q.cmp[1];
            REG_SUBM:   rd_data = SEC_W'({q.sub_qual, q.sub_cmp});
            REG_TRIM:   rd_data = SEC_W'(q.trim);
            REG_SUBCNT: rd_data = SEC_W'(sub_cnt);
            default:    rd_data = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        trim_rtc_match #(
            .SEC_W(SEC_W),
            .SUB_W(SUB_W)
        ) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .sec    (q.sec),
            .subsec (sub_cnt),
            .cmp_sec(q.cmp[i]),
            .cmp_sub(q.sub_cmp),
            .qual   ((i == 0) ? q.sub_qual : 1'b0),
            .evt    (match_evt[i])
        );
    end

    assign sec_cnt = q.sec;

endmodule

// File: rtl/trim_rtc_chk.sv
module trim_rtc_chk
    import trim_rtc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rtc_en,
    input logic                 tb_stb,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [SEC_W-1:0]     wr_data,
    input logic [SEC_W-1:0]     sec,
    input logic [SUB_W-1:0]     subsec,
    input logic [NUM_MATCH-1:0] match_evt
);

    logic sec_wr;
    assign sec_wr = wr_en && (wr_addr == REG_SECS);

    a_r1_evt_low_after_reset: assert property (@(posedge clk)
        !rst_n |=> (match_evt == '0));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rtc_en && tb_stb) && !sec_wr) |=> ($stable(sec) && $stable(subsec)));

    a_r2_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_en && tb_stb && !sec_wr) |=>
            ((sec == $past(sec) + 1'b1 && subsec == '0) ||
             (sec == $past(sec) && subsec == $past(subsec) + 1'b1)));

    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (sec == $past(wr_data)));

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_evt
        a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            match_evt[i] |=> !match_evt[i]);
    end

endmodule

bind trim_rtc trim_rtc_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rtc_en   (rtc_en),
    .tb_stb   (tb_stb),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sec      (sec_cnt),
    .subsec   (sub_cnt),
    .match_evt(match_evt)
);

// File: tb/sim_trim_rtc.sv
module sim_trim_rtc;

    localparam int NOM = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_en = 1'b0;
    logic        tb_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  match_evt;

    int checks = 0;
    int fails = 0;
    int ecnt0 = 0;
    int ecnt1 = 0;
    bit done = 1'b0;

    trim_rtc #(.NOM_RELOAD(16'(NOM))) u0 (
        .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .tb_stb(tb_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .match_evt(match_evt)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (match_evt[0]) ecnt0 = ecnt0 + 1;
            if (match_evt[1]) ecnt1 = ecnt1 + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int n);
        repeat (n) begin
            @(negedge clk);
            rtc_en = 1'b1; tb_stb = 1'b1;
        end
        @(negedge clk);
        rtc_en = 1'b0; tb_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rtc_en = 1'b0; tb_stb = 1'b0; wr_en = 1'b0;
        ecnt0 = 0; ecnt1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(3'd0, v); chk("R1 seconds", v, 0);
        rd(3'd5, v); chk("R1 subsec", v, 0);
        rd(3'd4, v); chk("R1 trim", v, NOM);
        rd(3'd1, v); chk("R1 match0", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1 match1", v, 32'hFFFF_FFFF);
        idle(3);
        chk("R1 no events", ecnt0 + ecnt1, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        strobe(3);
        rd(3'd5, v); chk("R2 subsec after 3", v, 3);
        rd(3'd0, v); chk("R2 seconds after 3", v, 0);
        strobe(5);
        rd(3'd0, v); chk("R2 seconds after 8", v, 1);
        rd(3'd5, v); chk("R3 subsec cleared", v, 0);
        strobe(16);
        rd(3'd0, v); chk("R2 seconds after 24", v, 3);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_reset();
        strobe(3);
        repeat (10) begin @(negedge clk); rtc_en = 1'b0; tb_stb = 1'b1; end
        repeat (10) begin @(negedge clk); rtc_en = 1'b1; tb_stb = 1'b0; end
        @(negedge clk); rtc_en = 1'b0; tb_stb = 1'b0;
        rd(3'd5, v); chk("R5 subsec held", v, 3);
        rd(3'd0, v); chk("R5 seconds held", v, 0);
        strobe(5);
        rd(3'd0, v); chk("R5 predivider held", v, 1);
    endtask

    task automatic t_trim();
        logic [31:0] v;
        do_reset();
        wr(3'd4, 32'd3);
        strobe(63 * (NOM + 1));
        rd(3'd0, v); chk("R4 sec 63", v, 63);
        strobe(NOM + 1);
        rd(3'd0, v); chk("R4 sec 64", v, 64);
        strobe(3);
        rd(3'd0, v); chk("R4 trim second not done", v, 64);
        rd(3'd5, v); chk("R4 trim second subsec", v, 3);
        strobe(1);
        rd(3'd0, v); chk("R4 trim second short", v, 65);
        strobe(NOM);
        rd(3'd0, v); chk("R4 nominal resumes", v, 65);
        strobe(1);
        rd(3'd0, v); chk("R4 nominal length", v, 66);
    endtask

    task automatic t_load();
        logic [31:0] v;
        do_reset();
        wr(3'd0, 32'h1234);
        rd(3'd0, v); chk("R6 load", v, 32'h1234);
        strobe(NOM + 1);
        rd(3'd0, v); chk("R6 count from load", v, 32'h1235);
        do_reset();
        strobe(NOM);
        @(negedge clk);
        rtc_en = 1'b1; tb_stb = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd100;
        @(negedge clk);
        rtc_en = 1'b0; tb_stb = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); chk("R6 load beats tick", v, 100);
        rd(3'd5, v); chk("R3 tick still clears subsec", v, 0);
    endtask

    task automatic t_match1();
        do_reset();
        wr(3'd2, 32'd2);
        strobe(2 * (NOM + 1));
        idle(3);
        chk("R7 match1 fired", ecnt1, 1);
        chk("R7 match0 silent", ecnt0, 0);
        strobe(NOM);
        idle(3);
        chk("R9 no repeat while equal", ecnt1, 1);
        strobe(1);
        wr(3'd0, 32'd2);
        idle(3);
        chk("R9 re-entry fires again", ecnt1, 2);
    endtask

    task automatic t_match0();
        do_reset();
        wr(3'd1, 32'd1);
        strobe(NOM + 3);
        idle(3);
        chk("R8 seconds-only match0", ecnt0, 1);
        do_reset();
        wr(3'd1, 32'd1);
        wr(3'd3, (32'd1 << 16) | 32'd5);
        strobe(NOM + 1);
        idle(3);
        chk("R8 qualified waits for subsec", ecnt0, 0);
        strobe(5);
        idle(3);
        chk("R8 qualified fires", ecnt0, 1);
        chk("R8 match1 silent", ecnt1, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        do_reset();
        strobe(3);
        wr(3'd5, 32'hAA);
        rd(3'd5, v); chk("R10 subsec not writable", v, 3);
        wr(3'd7, 32'h55);
        wr(3'd6, 32'h66);
        rd(3'd7, v); chk("R10 addr 7 reads 0", v, 0);
        rd(3'd6, v); chk("R10 addr 6 reads 0", v, 0);
        rd(3'd0, v); chk("R10 seconds untouched", v, 0);
        rd(3'd4, v); chk("R10 trim untouched", v, NOM);
        rd(3'd1, v); chk("R10 match0 untouched", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_trim();
        t_load();
        t_match1();
        t_match0();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule